// File: doc/BRIEF.md
# Set-Associative Tag and Permission Directory

This block holds the tag, state and recency information of a set-associative cache. It stores no data. A cache controller sends it one command per accepted request over a ready/valid port, always with a line-aligned address. The block answers one cycle later with a registered response.

The commands cover the whole life of a line:
- look up the line and check its permission for the request kind;
- test whether the line is present, or whether its set has room;
- allocate a way, or release it;
- ask which line would be evicted;
- make a line most recently used;
- set, clear or test an owner lock held by an execution context;
- rewrite a line's permission state.

Every way stores a tag, a valid bit, a two-bit permission, a lock-held bit and an owner context. Every set keeps true-LRU age counters.

A command that would break the directory's invariants is refused with an error flag and changes nothing. Such commands are an allocate of a line already present, an allocate into a full set, and a probe of a set that still has room. Lock and permission commands on an absent line are refused the same way. The controller uses the answers to decide between a hit, a fill and an eviction.

Top module: `tag_dir`

## Requirements
- R1: The set index is the address field of log2(SETS) bits starting at bit IDX_LO, and the tag is every bit above it. With the defaults, the set is addr[7:6] and the tag is addr[15:8]. A line in one set never affects a lookup in another set.
- R2: A hit requires a valid way whose tag matches and whose permission is not NotPresent. The permission codes are 0 NotPresent, 1 Invalid, 2 ReadOnly and 3 ReadWrite. A matching NotPresent way reports as a miss. rsp_perm gives the hit way's permission, or 0 on a miss.
- R3: rsp_grant is 1 only for a lookup (command 0) that hits, under one of two conditions. Either the line is ReadWrite, or the line is ReadOnly and the request kind is a load (kind 0) or an instruction fetch (kind 1). A store (kind 2) to a ReadOnly line is refused.
- R4: A lookup that hits makes the line most recently used even when the grant is refused. A set-MRU (command 6) does the same for a present line. Allocate also does it for the way it writes.
- R5: An availability test (command 2) returns rsp_flag=1 when any way of the set holds the tag, is empty, or is NotPresent.
- R6: Allocate (command 3) writes the lowest-numbered empty or NotPresent way. It sets the permission to Invalid, clears the lock and reports the way on rsp_way.
- R7: A victim probe (command 5) on a full set returns the way with the oldest age, ties going to the lowest index. It also returns that way's full line address on rsp_victim. After reset, way i has age i.
- R8: Lock-set (command 7) stores req_ctx as owner and lock-clear (command 8) removes the owner. Lock-test (command 9) returns rsp_flag=1 only when an owner is held and it equals req_ctx. A cleared lock matches no context, including 0.
- R9: Deallocate (command 4) of a present line empties its way. A later presence test (command 1) then misses, and the set becomes available. Deallocate of an absent line does nothing.
- R10: rsp_err=1 and no state change follow five kinds of command: allocate of a present line, allocate to a full set, probe of an available set, and lock commands (7, 8, 9) or permission writes (command 10) on an absent line.
- R11: A permission write (command 10) sets the hit way's permission to req_perm. Every accepted request yields rsp_valid exactly one cycle later, and no response appears without an accepted request.
- R12: During reset req_ready and rsp_valid are 0. Reset empties every way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_cmd | input | 4 | Command code (0..10) |
| req_addr | input | ADDR_W | Line-aligned address |
| req_kind | input | 2 | Request kind: 0 load, 1 fetch, 2 store |
| req_ctx | input | CTX_W | Context ID for lock commands |
| req_perm | input | 2 | Permission for command 10 |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Line present with a usable permission |
| rsp_way | output | log2(WAYS) | Hit, allocated or victim way |
| rsp_perm | output | 2 | Permission of the hit way |
| rsp_grant | output | 1 | Lookup access granted |
| rsp_flag | output | 1 | Availability or lock-test result |
| rsp_err | output | 1 | Illegal command, refused |
| rsp_victim | output | ADDR_W | Line address of the probe victim |

## Verification
A lookup can refuse access and update recency in the same cycle. This happens when a store hits an Invalid line: the grant stays low while the age state moves. The bench provokes it in a full set whose victim is known. It then issues a probe and expects the victim to move off the refused line to the next oldest way.

A second case needs the allocator and the hit path to judge the same set in one cycle. An allocate of a tag already held in a NotPresent way must take the lowest free way, and must not be treated as a duplicate.

// File: rtl/tdir_pkg.sv
// Shared encodings of the tag directory: command, permission and request kind.
package tdir_pkg;

    typedef enum logic [3:0] {
        CMD_LOOKUP  = 4'd0,
        CMD_PRESENT = 4'd1,
        CMD_AVAIL   = 4'd2,
        CMD_ALLOC   = 4'd3,
        CMD_DEALLOC = 4'd4,
        CMD_PROBE   = 4'd5,
        CMD_MRU     = 4'd6,
        CMD_LSET    = 4'd7,
        CMD_LCLR    = 4'd8,
        CMD_LTEST   = 4'd9,
        CMD_SETPERM = 4'd10
    } cmd_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_INV  = 2'd1,
        PERM_RO   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_STORE = 2'd2
    } kind_e;

endpackage

// File: rtl/tdir_match.sv
// Compares a request tag against every way of one set.
// Produces the hit way, the lowest free way and set availability.
// Assumes that an empty way holds permission NotPresent.
module tdir_match
    import tdir_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [TAG_W-1:0] way_tag  [WAYS],
    input  logic [1:0]       way_perm [WAYS],
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic [WW-1:0]    hit_way,
    output logic             free_any,
    output logic [WW-1:0]    free_way,
    output logic             avail
);

    logic [WAYS-1:0] tag_eq;
    logic [WAYS-1:0] hit_vec;
    logic [WAYS-1:0] free_vec;

    // Per-way compare and free detection.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_eq[w]   = way_valid[w] && (way_tag[w] == req_tag);
        assign hit_vec[w]  = tag_eq[w] && (way_perm[w] != PERM_NONE);
        assign free_vec[w] = !way_valid[w] || (way_perm[w] == PERM_NONE);
    end

    // Lowest-index priority pick for hit and free ways.
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way  = WW'(w);
            if (free_vec[w]) free_way = WW'(w);
        end
    end

    assign hit      = |hit_vec;
    assign free_any = |free_vec;
    assign avail    = free_any || (|tag_eq);

endmodule

// File: rtl/tdir_lru.sv
// True-LRU age state per set: age 0 is most recent, WAYS-1 oldest.
// A touch zeroes the touched way and ages every way that was younger than it.
// Assumes the ages of a set always form a permutation; reset gives way i age i.
module tdir_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SW  = $clog2(SETS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [SW-1:0] touch_set,
    input  logic [WW-1:0] touch_way,
    input  logic [SW-1:0] rd_set,
    output logic [WW-1:0] victim_way
);

    logic [WW-1:0] age_q [SETS][WAYS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // Age update of one set on reset or touch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WW'(w);
            end else if (touch_en && touch_set == SW'(s)) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WW'(w) == touch_way)
                        age_q[s][w] <= '0;
                    else if (age_q[s][w] < age_q[s][touch_way])
                        age_q[s][w] <= age_q[s][w] + 1'b1;
                end
            end
        end
    end

    // Oldest way of the read set, ties to the lowest index.
    always_comb begin
        logic [WW-1:0] best_age;
        victim_way = '0;
        best_age   = age_q[rd_set][0];
        for (int w = 1; w < WAYS; w++) begin
            if (age_q[rd_set][w] > best_age) begin
                victim_way = WW'(w);
                best_age   = age_q[rd_set][w];
            end
        end
    end

endmodule

// File: rtl/tag_dir.sv
// Set-associative tag and permission directory with one request port.
// Each accepted command is judged against the state before the edge.
// Its response is registered one cycle later, and illegal commands leave state untouched.
// Assumes line-aligned addresses; the bits below IDX_LO are ignored.
module tag_dir
    import tdir_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int IDX_LO = 6,
    parameter int CTX_W  = 4,
    localparam int SW    = $clog2(SETS),
    localparam int WW    = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_LO - SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [1:0]        req_perm,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WW-1:0]     rsp_way,
    output logic [1:0]        rsp_perm,
    output logic              rsp_grant,
    output logic              rsp_flag,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_victim
);

    // Directory storage.
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [1:0]       perm_q  [SETS][WAYS];
    logic [WAYS-1:0]  held_q  [SETS];
    logic [CTX_W-1:0] owner_q [SETS][WAYS];
    logic             ready_q;

    logic [SW-1:0]    set_idx;
    logic [TAG_W-1:0] req_tag;
    logic [TAG_W-1:0] cur_tag  [WAYS];
    logic [1:0]       cur_perm [WAYS];
    logic             hit, free_any, avail;
    logic [WW-1:0]    hit_way, free_way, vic_way;
    logic             accept, err_c, touch_en, do_upd;
    logic             is_lookup, is_alloc, is_probe, is_lock, is_perm;
    logic             grant_c, flag_c;
    logic [WW-1:0]    way_c;
    logic [ADDR_W-1:0] victim_c;

    assign set_idx = req_addr[IDX_LO +: SW];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign accept  = req_valid && req_ready;
    assign req_ready = ready_q;

    // Gather the ways of the addressed set for the comparator.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            cur_tag[w]  = tag_q[set_idx][w];
            cur_perm[w] = perm_q[set_idx][w];
        end
    end

    tdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
        .way_valid (valid_q[set_idx]),
        .way_tag   (cur_tag),
        .way_perm  (cur_perm),
        .req_tag   (req_tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .free_any  (free_any),
        .free_way  (free_way),
        .avail     (avail)
    );

    tdir_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_set  (set_idx),
        .touch_way  (is_alloc ? free_way : hit_way),
        .rd_set     (set_idx),
        .victim_way (vic_way)
    );

    // Command decode, legality and response values.
    always_comb begin
        is_lookup = req_cmd == CMD_LOOKUP;
        is_alloc  = req_cmd == CMD_ALLOC;
        is_probe  = req_cmd == CMD_PROBE;
        is_lock   = req_cmd == CMD_LSET || req_cmd == CMD_LCLR || req_cmd == CMD_LTEST;
        is_perm   = req_cmd == CMD_SETPERM;
        err_c     = (is_alloc && (hit || !avail)) || (is_probe && avail)
                  || ((is_lock || is_perm) && !hit);
        grant_c   = is_lookup && hit
                  && (perm_q[set_idx][hit_way] == PERM_RW
                      || (perm_q[set_idx][hit_way] == PERM_RO && req_kind != KIND_STORE));
        flag_c    = 1'b0;
        if (req_cmd == CMD_AVAIL)
            flag_c = avail;
        else if (req_cmd == CMD_LTEST && hit)
            flag_c = held_q[set_idx][hit_way] && owner_q[set_idx][hit_way] == req_ctx;
        if (is_alloc && !err_c)      way_c = free_way;
        else if (is_probe && !err_c) way_c = vic_way;
        else if (hit)                way_c = hit_way;
        else                         way_c = '0;
        victim_c = (is_probe && !err_c)
                 ? {tag_q[set_idx][vic_way], set_idx, {IDX_LO{1'b0}}} : '0;
        do_upd   = accept && !err_c;
        touch_en = do_upd && (is_alloc || ((is_lookup || req_cmd == CMD_MRU) && hit));
    end

    // Ready comes up one cycle after reset is released.
    always_ff @(posedge clk) begin
        ready_q <= rst_n;
    end

    // Registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_perm   <= '0;
            rsp_grant  <= 1'b0;
            rsp_flag   <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_victim <= '0;
        end else begin
            rsp_valid  <= accept;
            rsp_hit    <= hit;
            rsp_way    <= way_c;
            rsp_perm   <= hit ? perm_q[set_idx][hit_way] : PERM_NONE;
            rsp_grant  <= grant_c;
            rsp_flag   <= flag_c;
            rsp_err    <= err_c;
            rsp_victim <= victim_c;
        end
    end

    // Directory state update for legal commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                held_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    perm_q[s][w]  <= PERM_NONE;
                    owner_q[s][w] <= '0;
                end
            end
        end else if (do_upd) begin
            case (req_cmd)
                CMD_ALLOC: begin
                    valid_q[set_idx][free_way] <= 1'b1;
                    tag_q[set_idx][free_way]   <= req_tag;
                    perm_q[set_idx][free_way]  <= PERM_INV;
                    held_q[set_idx][free_way]  <= 1'b0;
                    owner_q[set_idx][free_way] <= '0;
                end
                CMD_DEALLOC: if (hit) begin
                    valid_q[set_idx][hit_way] <= 1'b0;
                    tag_q[set_idx][hit_way]   <= '0;
                    perm_q[set_idx][hit_way]  <= PERM_NONE;
                    held_q[set_idx][hit_way]  <= 1'b0;
                    owner_q[set_idx][hit_way] <= '0;
                end
                CMD_LSET: begin
                    held_q[set_idx][hit_way]  <= 1'b1;
                    owner_q[set_idx][hit_way] <= req_ctx;
                end
                CMD_LCLR: begin
                    held_q[set_idx][hit_way]  <= 1'b0;
                    owner_q[set_idx][hit_way] <= '0;
                end
                CMD_SETPERM: perm_q[set_idx][hit_way] <= req_perm;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tdir_checker.sv
// Protocol and response properties of the tag directory, bound to tag_dir.
// Assumes the response is judged against the request accepted one cycle before.
module tdir_checker
    import tdir_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int IDX_LO = 6,
    localparam int SW    = $clog2(SETS),
    localparam int WW    = $clog2(WAYS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        req_cmd,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_kind,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WW-1:0]     rsp_way,
    input logic [1:0]        rsp_perm,
    input logic              rsp_grant,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] rsp_victim
);

    // A response only follows an accepted request.
    p_rsp_follows_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    // A held-off cycle produces no response.
    p_no_rsp_when_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !rsp_valid);

    // A grant needs a hit and a permission matching the request kind.
    p_grant_rules_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |->
            (rsp_hit && (rsp_perm == PERM_RW
                         || (rsp_perm == PERM_RO && $past(req_kind) != KIND_STORE))));

    // A hit never reports a NotPresent line.
    p_hit_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> rsp_perm != PERM_NONE);

    // Allocating a line that is already present is refused.
    p_alloc_dup_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_cmd) == CMD_ALLOC && rsp_hit) |-> rsp_err);

    // A legal probe returns a line address in the requested set.
    p_probe_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_cmd) == CMD_PROBE && !rsp_err) |->
            rsp_victim[IDX_LO +: SW] == $past(req_addr[IDX_LO +: SW]));

endmodule

bind tag_dir tdir_checker #(
    .ADDR_W (ADDR_W),
    .SETS   (SETS),
    .WAYS   (WAYS),
    .IDX_LO (IDX_LO)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cmd    (req_cmd),
    .req_addr   (req_addr),
    .req_kind   (req_kind),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_perm   (rsp_perm),
    .rsp_grant  (rsp_grant),
    .rsp_err    (rsp_err),
    .rsp_victim (rsp_victim)
);

// File: tb/tag_dir_tb_top.sv
// Vector-driven bench for tag_dir with default parameters.
// The set is addr[7:6] and the tag is addr[15:8].
module tag_dir_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    typedef struct packed {
        logic [3:0] cmd;
        logic [7:0] tag;
        logic [1:0] set;
        logic [1:0] kind;
        logic [3:0] ctx;
        logic [1:0] perm;
        logic       hit;
        logic [1:0] way;
        logic [1:0] rperm;
        logic       grant;
        logic       flag;
        logic       err;
        logic [7:0] vtag;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 49;
    // cmd, tag, set, kind, ctx, perm | hit, way, perm, grant, flag, err, victim tag, requirement
    localparam vec_t VEC [NV] = '{
        '{0, 'h11, 1, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     2},  // R2 empty miss
        '{2, 'h11, 1, 0, 0, 0,  0, 0, 0, 0, 1, 0, 0,     5},  // R5 empty set
        '{5, 'h11, 1, 0, 0, 0,  0, 0, 0, 0, 0, 1, 0,    10},  // R10 probe on available
        '{7, 'h11, 1, 0, 3, 0,  0, 0, 0, 0, 0, 1, 0,    10},  // R10 lock absent
        '{3, 'h11, 1, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     6},  // R6 first alloc way0
        '{3, 'h11, 1, 0, 0, 0,  1, 0, 1, 0, 0, 1, 0,    10},  // R10 duplicate alloc
        '{0, 'h11, 1, 0, 0, 0,  1, 0, 1, 0, 0, 0, 0,     3},  // R3 Invalid no grant
        '{10,'h11, 1, 0, 0, 2,  1, 0, 1, 0, 0, 0, 0,    11},  // R11 set ReadOnly
        '{0, 'h11, 1, 2, 0, 0,  1, 0, 2, 0, 0, 0, 0,     3},  // R3 store to RO refused
        '{0, 'h11, 1, 1, 0, 0,  1, 0, 2, 1, 0, 0, 0,     3},  // R3 fetch RO granted
        '{0, 'h11, 1, 0, 0, 0,  1, 0, 2, 1, 0, 0, 0,     3},  // R3 load RO granted
        '{10,'h11, 1, 0, 0, 3,  1, 0, 2, 0, 0, 0, 0,    11},  // R11 set ReadWrite
        '{0, 'h11, 1, 2, 0, 0,  1, 0, 3, 1, 0, 0, 0,     3},  // R3 store RW granted
        '{3, 'h22, 1, 0, 0, 0,  0, 1, 0, 0, 0, 0, 0,     6},  // R6 way1
        '{3, 'h33, 1, 0, 0, 0,  0, 2, 0, 0, 0, 0, 0,     6},  // R6 way2
        '{3, 'h44, 1, 0, 0, 0,  0, 3, 0, 0, 0, 0, 0,     6},  // R6 way3
        '{2, 'h55, 1, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     5},  // R5 full, absent
        '{2, 'h33, 1, 0, 0, 0,  1, 2, 1, 0, 1, 0, 0,     5},  // R5 full, held
        '{3, 'h55, 1, 0, 0, 0,  0, 0, 0, 0, 0, 1, 0,    10},  // R10 alloc full set
        '{5, 'h55, 1, 0, 0, 0,  0, 0, 0, 0, 0, 0, 'h11,  7},  // R7 oldest way0
        '{0, 'h11, 1, 0, 0, 0,  1, 0, 3, 1, 0, 0, 0,     4},  // R4 touch way0
        '{5, 'h55, 1, 0, 0, 0,  0, 1, 0, 0, 0, 0, 'h22,  7},  // R7 now way1
        '{6, 'h22, 1, 0, 0, 0,  1, 1, 1, 0, 0, 0, 0,     4},  // R4 set-MRU way1
        '{5, 'h55, 1, 0, 0, 0,  0, 2, 0, 0, 0, 0, 'h33,  7},  // R7 now way2
        '{0, 'h33, 1, 2, 0, 0,  1, 2, 1, 0, 0, 0, 0,     4},  // R4 refused hit
        '{5, 'h55, 1, 0, 0, 0,  0, 3, 0, 0, 0, 0, 'h44,  4},  // R4 refusal still touched
        '{7, 'h22, 1, 0, 5, 0,  1, 1, 1, 0, 0, 0, 0,     8},  // R8 lock ctx5
        '{9, 'h22, 1, 0, 5, 0,  1, 1, 1, 0, 1, 0, 0,     8},  // R8 owner match
        '{9, 'h22, 1, 0, 4, 0,  1, 1, 1, 0, 0, 0, 0,     8},  // R8 other ctx
        '{8, 'h22, 1, 0, 0, 0,  1, 1, 1, 0, 0, 0, 0,     8},  // R8 clear
        '{9, 'h22, 1, 0, 5, 0,  1, 1, 1, 0, 0, 0, 0,     8},  // R8 cleared
        '{9, 'h22, 1, 0, 0, 0,  1, 1, 1, 0, 0, 0, 0,     8},  // R8 no owner != ctx0
        '{4, 'h33, 1, 0, 0, 0,  1, 2, 1, 0, 0, 0, 0,     9},  // R9 dealloc way2
        '{1, 'h33, 1, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     9},  // R9 now absent
        '{2, 'h55, 1, 0, 0, 0,  0, 0, 0, 0, 1, 0, 0,     9},  // R9 set available
        '{5, 'h55, 1, 0, 0, 0,  0, 0, 0, 0, 0, 1, 0,    10},  // R10 probe available
        '{3, 'h55, 1, 0, 0, 0,  0, 2, 0, 0, 0, 0, 0,     6},  // R6 reuse way2
        '{9, 'h55, 1, 0, 0, 0,  1, 2, 1, 0, 0, 0, 0,     6},  // R6 lock cleared
        '{10,'h55, 1, 0, 0, 0,  1, 2, 1, 0, 0, 0, 0,    11},  // R11 set NotPresent
        '{0, 'h55, 1, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     2},  // R2 NotPresent miss
        '{2, 'h66, 1, 0, 0, 0,  0, 0, 0, 0, 1, 0, 0,     5},  // R5 NotPresent way free
        '{3, 'h66, 1, 0, 0, 0,  0, 2, 0, 0, 0, 0, 0,     6},  // R6 take NotPresent way
        '{1, 'h66, 1, 0, 0, 0,  1, 2, 1, 0, 0, 0, 0,     2},  // R2 present
        '{0, 'h11, 2, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     1},  // R1 other set miss
        '{3, 'h11, 2, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     1},  // R1 other set way0
        '{1, 'h11, 1, 0, 0, 0,  1, 0, 3, 0, 0, 0, 0,     1},  // R1 set1 untouched
        '{4, 'h77, 3, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0,     9},  // R9 absent dealloc no-op
        '{10,'h77, 3, 0, 0, 3,  0, 0, 0, 0, 0, 1, 0,    10},  // R10 perm absent
        '{5, 'h55, 1, 0, 0, 0,  0, 3, 0, 0, 0, 0, 'h44,  7}   // R7 errors left ages alone
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_cmd = '0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [3:0]  req_ctx = '0;
    logic [1:0]  req_perm = '0;
    logic        rsp_valid, rsp_hit, rsp_grant, rsp_flag, rsp_err;
    logic [1:0]  rsp_way, rsp_perm;
    logic [15:0] rsp_victim;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    tag_dir dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_kind(req_kind),
        .req_ctx(req_ctx), .req_perm(req_perm), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_perm(rsp_perm),
        .rsp_grant(rsp_grant), .rsp_flag(rsp_flag), .rsp_err(rsp_err),
        .rsp_victim(rsp_victim)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_LIMIT && !done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WDOG_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge: present one request, return at the next falling edge.
    task automatic issue(input logic [3:0] c, input logic [7:0] t, input logic [1:0] s,
                         input logic [1:0] k, input logic [3:0] x, input logic [1:0] p);
        req_valid = 1'b1;
        req_cmd   = c;
        req_addr  = {t, s, 6'b0};
        req_kind  = k;
        req_ctx   = x;
        req_perm  = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        // R12: reset state, with a request held during reset.
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 ready in reset", {31'b0, req_ready}, 32'd0);
        check("R12 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 ready after reset", {31'b0, req_ready}, 32'd1);
        check("R12 no response from reset-time request", {31'b0, rsp_valid}, 32'd0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [15:0] evic;
            v = VEC[i];
            issue(v.cmd, v.tag, v.set, v.kind, v.ctx, v.perm);
            evic = (v.cmd == 4'd5 && !v.err) ? {v.vtag, v.set, 6'b0} : 16'h0;
            check($sformatf("R%0d vector %0d", v.req, i),
                  {7'b0, rsp_valid, rsp_hit, rsp_way, rsp_perm, rsp_grant, rsp_flag, rsp_err, rsp_victim},
                  {7'b0, 1'b1, v.hit, v.way, v.rperm, v.grant, v.flag, v.err, evic});
        end

        // R11: an idle cycle brings no response.
        @(negedge clk);
        check("R11 idle gives no response", {31'b0, rsp_valid}, 32'd0);

        // R12: reset in mid-run empties the directory.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        issue(4'd1, 8'h11, 2'd1, 2'd0, 4'd0, 2'd0);
        check("R12 line gone after reset", {30'b0, rsp_valid, rsp_hit}, 32'd2);
        issue(4'd2, 8'h55, 2'd1, 2'd0, 4'd0, 2'd0);
        check("R12 set available after reset", {30'b0, rsp_flag, rsp_err}, 32'd2);
        issue(4'd5, 8'h55, 2'd1, 2'd0, 4'd0, 2'd0);
        check("R10 probe after reset refused", {31'b0, rsp_err}, 32'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule